// File: doc/BRIEF.md
# Sixteen-Entry Colour Palette with Rotated Channel Weights

This block is a small colour lookup table for a display pipeline. A processor loads sixteen 16-bit colour words through a simple write port, one entry per word offset, and can read any entry back. During display, a 4-bit pixel index picks one entry each clock. The block then presents that entry as three 4-bit linear intensities, one each for red, green and blue, on a registered output.

Inside each stored channel nibble, the bits do not sit in plain binary weight order. The weight-1 bit sits at the top of the nibble, and the three lower bits carry weights 8, 4 and 2. This lets software written for an older three-bit-per-channel format keep producing bright colours. The block undoes this order on the way out, so the outputs are plain binary intensities.

The pixel path is one register deep. A processor write to the entry being looked up in the same cycle is forwarded, so the output after that edge already shows the new colour.

Top module: `pal_lut`

## Requirements
- R1: A write with `cpu_we` high stores `cpu_wdata` into the entry chosen by `cpu_widx`. `cpu_widx` is the word offset, which is bits 4:1 of byte offsets 0x00 to 0x1E. From the next cycle, `cpu_rdata` for that index returns the stored value.
- R2: A write changes only the addressed entry. Every other entry keeps its value.
- R3: Bits 15:12 of `cpu_rdata` always read as zero, whatever was written to them.
- R4: In a stored word, red lies in bits 11:8, green in bits 7:4 and blue in bits 3:0. Each channel drives its own output port.
- R5: For a stored nibble n, the output intensity is {n[2:0], n[3]}. The stored sequence 0x0, 0x8, 0x1, 0x9, 0x2, 0xA, ... therefore yields 0, 1, 2, 3, 4, 5, ...
- R6: A nibble written in the older format, with the top bit clear and a value v in bits 2:0, yields intensity 2·v. For example, 0x7 gives 14.
- R7: The output registers the colour for `pix_idx` one clock after that index is applied. Between those edges, the outputs hold their previous value.
- R8: After reset, every entry is zero and all three outputs are zero.
- R9: If a write hits the entry that `pix_idx` selects in the same cycle, the outputs after that edge show the newly written colour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Write strobe |
| cpu_widx | input | 4 | Entry word offset (byte offset bits 4:1) |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Readback of the entry at `cpu_widx`; upper nibble zero |
| pix_idx | input | 4 | Pixel colour index |
| red | output | 4 | Linear red intensity, registered |
| green | output | 4 | Linear green intensity, registered |
| blue | output | 4 | Linear blue intensity, registered |

## Verification
The pixel lookup and a processor write can land on the same entry in the same clock. The bench provokes this by holding `pix_idx` on one entry and writing a new colour to that entry on the same edge. It then requires the outputs at the following sample point to match the new colour, not the old one. A second case writes a neighbouring entry during the same lookup and requires the output to stay unchanged.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int CH_W   = 4;
    localparam int N_CH   = 3;
    localparam int COLOR_W = CH_W * N_CH;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;
endpackage

// File: rtl/pal_store.sv
module pal_store #(
    parameter int ENTRIES = 16,
    parameter int COLOR_W = 12,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   widx,
    input  logic [COLOR_W-1:0] wdata,
    output logic [COLOR_W-1:0] rdata_cpu,
    input  logic [IDX_W-1:0]   ridx_pix,
    output logic [COLOR_W-1:0] rdata_pix
);
    logic [COLOR_W-1:0] mem [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[e] <= '0;
            end else if (we && (widx == IDX_W'(e))) begin
                mem[e] <= wdata;
            end
        end

        AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && (widx == IDX_W'(e))) |=> $stable(mem[e])); // R2
    end

    assign rdata_cpu = mem[widx];
    assign rdata_pix = mem[ridx_pix];
endmodule

// File: rtl/pal_linearize.sv
module pal_linearize #(
    parameter int CH_W = 4,
    parameter int N_CH = 3,
    localparam int TOT_W = CH_W * N_CH
) (
    input  logic [TOT_W-1:0] stored,
    output logic [TOT_W-1:0] linear
);
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [CH_W-1:0] nib;
        assign nib = stored[c*CH_W +: CH_W];
        assign linear[c*CH_W +: CH_W] = {nib[CH_W-2:0], nib[CH_W-1]};
    end
endmodule

// File: rtl/pal_lut.sv
module pal_lut #(
    parameter int ENTRIES = 16,
    parameter int WORD_W  = 16,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int CH_W   = pal_pkg::CH_W,
    localparam int COLOR_W = pal_pkg::COLOR_W,
    localparam int PAD_W  = WORD_W - COLOR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [IDX_W-1:0]  cpu_widx,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic [CH_W-1:0]   red,
    output logic [CH_W-1:0]   green,
    output logic [CH_W-1:0]   blue
);
    import pal_pkg::*;

    logic [COLOR_W-1:0] store_cpu;
    logic [COLOR_W-1:0] store_pix;
    logic [COLOR_W-1:0] sel_raw;
    logic [COLOR_W-1:0] sel_lin;
    logic               hit;
    logic               unused_wdata_hi;
    rgb_t               rgb_q;

    assign unused_wdata_hi = ^cpu_wdata[WORD_W-1:COLOR_W];

    pal_store #(.ENTRIES(ENTRIES), .COLOR_W(COLOR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cpu_we),
        .widx      (cpu_widx),
        .wdata     (cpu_wdata[COLOR_W-1:0]),
        .rdata_cpu (store_cpu),
        .ridx_pix  (pix_idx),
        .rdata_pix (store_pix)
    );

    assign hit     = cpu_we && (cpu_widx == pix_idx);
    assign sel_raw = hit ? cpu_wdata[COLOR_W-1:0] : store_pix;

    pal_linearize #(.CH_W(CH_W), .N_CH(N_CH)) u_lin (
        .stored (sel_raw),
        .linear (sel_lin)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgb_q <= '0;
        end else begin
            rgb_q <= rgb_t'(sel_lin);
        end
    end

    assign red       = rgb_q.r;
    assign green     = rgb_q.g;
    assign blue      = rgb_q.b;
    assign cpu_rdata = {{PAD_W{1'b0}}, store_cpu};

    AST_RDBACK: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_we |=> (cpu_widx != $past(cpu_widx)) ||
                   (cpu_rdata == {{PAD_W{1'b0}}, $past(cpu_wdata[COLOR_W-1:0])})); // R1

    AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !$past(rst_n) ||
                (red == {$past(cpu_wdata[3*CH_W-2:2*CH_W]), $past(cpu_wdata[3*CH_W-1])})); // R9

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !$past(rst_n) ||
                 (blue == {$past(store_pix[CH_W-2:0]), $past(store_pix[CH_W-1])})); // R7

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_we |=> (cpu_rdata[WORD_W-1:COLOR_W] == '0)); // R3
endmodule

// File: tb/sim_pal_lut.sv
module sim_pal_lut;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [3:0]  cpu_widx = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic [3:0]  pix_idx = '0;
    logic [3:0]  red, green, blue;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pal_lut u0 (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_widx(cpu_widx),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pix_idx(pix_idx),
        .red(red), .green(green), .blue(blue)
    );

    // {stored word, expected linear rgb}; channel nibbles R=i, G=i+5, B=15-i, upper nibble 0xA
    localparam logic [27:0] VEC [16] = '{
        {16'hA05F, 12'h0AF}, {16'hA16E, 12'h2CD}, {16'hA27D, 12'h4EB}, {16'hA38C, 12'h619},
        {16'hA49B, 12'h837}, {16'hA5AA, 12'hA55}, {16'hA6B9, 12'hC73}, {16'hA7C8, 12'hE91},
        {16'hA8D7, 12'h1BE}, {16'hA9E6, 12'h3DC}, {16'hAAF5, 12'h5FA}, {16'hAB04, 12'h708},
        {16'hAC13, 12'h926}, {16'hAD22, 12'hB44}, {16'hAE31, 12'hD62}, {16'hAF40, 12'hF80}
    };

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [15:0] data);
        cpu_we = 1'b1; cpu_widx = idx; cpu_wdata = data;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic look(input logic [3:0] idx);
        pix_idx = idx;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk({4'h0, red, green, blue}, 16'h0000, "R8 outputs in reset");
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            cpu_widx = 4'(i);
            #1 chk(cpu_rdata, 16'h0000, "R8 entry zero after reset");
        end
        look(4'd5);
        chk({4'h0, red, green, blue}, 16'h0000, "R8 lookup after reset");

        // table: write all, read back all, look up all
        for (int i = 0; i < 16; i++) wr(4'(i), VEC[i][27:12]);
        for (int i = 0; i < 16; i++) begin
            cpu_widx = 4'(i);
            #1 chk(cpu_rdata, {4'h0, VEC[i][23:12]}, "R1 R2 R3 readback");
        end
        for (int i = 0; i < 16; i++) begin
            look(4'(i));
            chk({4'h0, red, green, blue}, {4'h0, VEC[i][11:0]}, "R4 R5 lookup");
        end

        // R7: output holds until the edge after the index changes
        look(4'd2);
        pix_idx = 4'd9;
        #1 chk({4'h0, red, green, blue}, 16'h04EB, "R7 before edge");
        @(negedge clk);
        chk({4'h0, red, green, blue}, 16'h03DC, "R7 after one edge");

        // R5: ramp 0x000,0x888,0x111,0x999 -> 0,1,2,3
        wr(4'd0, 16'h0888); look(4'd0);
        chk({4'h0, red, green, blue}, 16'h0111, "R5 ramp step 1");
        wr(4'd0, 16'h0999); look(4'd0);
        chk({4'h0, red, green, blue}, 16'h0333, "R5 ramp step 3");

        // R6: older three-bit format
        wr(4'd3, 16'h0777); look(4'd3);
        chk({4'h0, red, green, blue}, 16'h0EEE, "R6 full white");
        wr(4'd3, 16'h0123); look(4'd3);
        chk({4'h0, red, green, blue}, 16'h0246, "R6 mixed");

        // R3: upper bits written as ones
        wr(4'd7, 16'hFFFF); cpu_widx = 4'd7;
        #1 chk(cpu_rdata, 16'h0FFF, "R3 upper nibble zero");

        // R9: write to looked-up entry in same cycle
        look(4'd4);
        pix_idx = 4'd4;
        wr(4'd4, 16'h0F00);
        chk({4'h0, red, green, blue}, 16'h0F00, "R9 same-cycle write forwarded");
        // R2: write to a different entry leaves output unchanged
        wr(4'd5, 16'h0123);
        chk({4'h0, red, green, blue}, 16'h0F00, "R2 neighbour write no effect");
        cpu_widx = 4'd6;
        #1 chk(cpu_rdata, {4'h0, VEC[6][23:12]}, "R2 other entry kept");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule